// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block is the supervisory state machine of a supply-management chip. It decides which of seven operating states the chip is in: unpowered, normal-request, normal, standby, stop, sleep and reset. From that state it drives the main regulator enable, the low-current select for the main regulator, the control enable of the secondary regulator, an active-low reset output to the host processor, and an active-low interrupt output. It consumes a periodic time-base tick, a supply-low comparator, a main-regulator undervoltage flag, a watchdog fault strobe, a wake strobe, the chip-select line, an end-of-frame strobe from the serial shifter, and decoded writes and reads of the mode and watchdog-timing registers.

After power-up and after every wake, the block enters a timed normal-request state. It first pulses reset. It then gives the host a bounded window in which to program the watchdog timing. If the host misses that window, the controller either cycles through reset, while the battery-fail flag is still unread, or drops back to the low-power mode it came from. Every timer length is a parameter counted in ticks, so the block can run at full scale on silicon and scaled down in simulation.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst` is high, the block sits in the unpowered state (status 0) with `main_en`=0, `sec_en`=0, `rst_n_out`=0, `int_n`=1 and `batfail`=1. On the first clock after release it moves to normal-request.
- R2: On entry to normal-request, `rst_n_out` is held low for RST_TICKS ticks and is then released. A configuration window of CFG_TICKS ticks then opens. `rst_n_out` is high in normal and standby.
- R3: A watchdog-timing write (`wdt_wr`) inside the window moves the block to normal, or to standby if a standby command was written earlier in the same normal-request visit. A `wdt_wr` during the reset pulse is ignored.
- R4: If the window expires while `batfail`=1, the block enters reset for RST_TICKS ticks and then returns to normal-request. This repeats for as long as the flag stays set.
- R5: If the window expires while `batfail`=0, the block returns to the last low-power mode it used (sleep or stop). After power-up that mode is sleep.
- R6: `batfail` is set the clock after `supply_low` is seen high. It is cleared only by a mode-register read (`mode_rd`).
- R7: A `mode_wr` with `mode_data` selects the following. 001 selects normal. 010 selects standby. 011 and 111 select stop. 100 selects sleep. 000 does nothing. 101 selects normal with the watchdog disabled (`wd_disable`=1), and 110 selects standby, but only while `batfail`=1; otherwise both do nothing.
- R8: A stop command does not change the state by itself. Stop is entered STOP_TICKS ticks after the next `frame_end` strobe.
- R9: In normal or standby, `vreg_uv` or a `wd_fault` strobe enters reset. A `wd_fault` is ignored once `wd_disable` is set. Reset lasts at least RST_TICKS ticks and is left for normal-request only when `vreg_uv` is low.
- R10: If `vreg_uv` stays high for UV_TICKS ticks in reset, the block goes to sleep.
- R11: `sec_en` is high only in normal. `main_en` is high in every state except sleep and unpowered. `main_lowpwr` is high in stop.
- R12: A `wake` strobe or a rising edge on `csb` in stop or sleep enters normal-request. A wake from stop also drives `int_n` low for INT_TICKS ticks.
- R13: `state_o` encodes the state as follows: 0 unpowered, 1 normal-request, 2 normal, 3 standby, 4 stop, 5 sleep, 6 reset. `mode_chg` is high for exactly the cycle in which `state_o` shows a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| tick_us | input | 1 | Time-base tick; timers count these |
| supply_low | input | 1 | Battery supply below fail threshold |
| vreg_uv | input | 1 | Main regulator below reset threshold |
| wd_fault | input | 1 | Watchdog failure strobe |
| wake | input | 1 | Wake event strobe (bus, wake inputs, timer) |
| csb | input | 1 | Serial chip-select level |
| frame_end | input | 1 | End of serial frame strobe |
| mode_wr | input | 1 | Mode register write strobe |
| mode_data | input | 3 | Mode command bits |
| wdt_wr | input | 1 | Watchdog-timing register write strobe |
| mode_rd | input | 1 | Mode register read strobe |
| main_en | output | 1 | Main regulator enable |
| main_lowpwr | output | 1 | Main regulator low-current mode |
| sec_en | output | 1 | Secondary regulator control enable |
| rst_n_out | output | 1 | Active-low reset to host |
| int_n | output | 1 | Active-low interrupt to host |
| wd_disable | output | 1 | Watchdog disabled by debug command |
| batfail | output | 1 | Battery-fail flag |
| state_o | output | 3 | Current state code |
| mode_chg | output | 1 | State changed this cycle |

## Verification
The bench builds the controller with RST_TICKS=8, CFG_TICKS=40, STOP_TICKS=3, INT_TICKS=2 and UV_TICKS=30, and holds the tick high on every clock. With these values, the reset pulse, the configuration window, the stop delay, the interrupt pulse and the undervoltage-to-sleep escape can each be measured to the exact cycle. Scaling the timers down also lets repeated window expiries and wake cycles fit in a short run.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_UNPOW = 3'd0,
    ST_NREQ  = 3'd1,
    ST_NORM  = 3'd2,
    ST_STBY  = 3'd3,
    ST_STOP  = 3'd4,
    ST_SLEEP = 3'd5,
    ST_RESET = 3'd6
  } pstate_t;

  typedef enum logic [2:0] {
    C_NONE  = 3'd0,
    C_NORM  = 3'd1,
    C_STBY  = 3'd2,
    C_STOP  = 3'd3,
    C_SLEEP = 3'd4,
    C_DBG   = 3'd5
  } cmd_t;

  localparam int NUM_TMR = 4;
  localparam int TM_MAIN = 0;
  localparam int TM_STOP = 1;
  localparam int TM_INT  = 2;
  localparam int TM_UV   = 3;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pwr_seq_decode.sv
module pwr_seq_decode
  import pwr_seq_pkg::*;
(
  input  logic       wr,
  input  logic [2:0] data,
  input  logic       bf,
  output cmd_t       cmd
);
  always_comb begin
    cmd = C_NONE;
    if (wr) begin
      if (data[1:0] == 2'b11) begin
        cmd = C_STOP;
      end else begin
        case (data)
          3'b001:  cmd = C_NORM;
          3'b010:  cmd = C_STBY;
          3'b100:  cmd = C_SLEEP;
          3'b101:  cmd = bf ? C_DBG  : C_NONE;
          3'b110:  cmd = bf ? C_STBY : C_NONE;
          default: cmd = C_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwr_seq_batflag.sv
module pwr_seq_batflag (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic rd,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b1;
    end else if (supply_low) begin
      flag <= 1'b1;
    end else if (rd) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int RST_TICKS  = 1000,
  parameter int CFG_TICKS  = 400000,
  parameter int STOP_TICKS = 20,
  parameter int INT_TICKS  = 10,
  parameter int UV_TICKS   = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_us,
  input  logic       supply_low,
  input  logic       vreg_uv,
  input  logic       wd_fault,
  input  logic       wake,
  input  logic       csb,
  input  logic       frame_end,
  input  logic       mode_wr,
  input  logic [2:0] mode_data,
  input  logic       wdt_wr,
  input  logic       mode_rd,
  output logic       main_en,
  output logic       main_lowpwr,
  output logic       sec_en,
  output logic       rst_n_out,
  output logic       int_n,
  output logic       wd_disable,
  output logic       batfail,
  output logic [2:0] state_o,
  output logic       mode_chg
);
  localparam int MAX_A = (RST_TICKS > CFG_TICKS) ? RST_TICKS : CFG_TICKS;
  localparam int MAX_B = (MAX_A > UV_TICKS) ? MAX_A : UV_TICKS;
  localparam int MAX_C = (MAX_B > STOP_TICKS) ? MAX_B : STOP_TICKS;
  localparam int MAX_T = (MAX_C > INT_TICKS) ? MAX_C : INT_TICKS;
  localparam int TW    = $clog2(MAX_T + 1);
  localparam logic [TW-1:0] RST_M1  = TW'(RST_TICKS - 1);
  localparam logic [TW-1:0] CFG_M1  = TW'(CFG_TICKS - 1);
  localparam logic [TW-1:0] STOP_M1 = TW'(STOP_TICKS - 1);
  localparam logic [TW-1:0] INT_M1  = TW'(INT_TICKS - 1);
  localparam logic [TW-1:0] UV_M1   = TW'(UV_TICKS - 1);

  pstate_t state, state_d, lp_prev, lp_d;
  logic    win, win_d;
  logic    stby_pend, stby_d, dbg_pend, dbg_d;
  logic    wd_dis, wdd_d;
  logic    stop_arm, stop_arm_d, stop_run, stop_run_d;
  logic    int_act, int_act_d, int_set;
  logic    csb_q, csb_rise;
  cmd_t    cmd;

  logic [NUM_TMR-1:0] tmr_ld;
  logic [NUM_TMR-1:0] tmr_zero;
  logic [TW-1:0]      tmr_val [NUM_TMR];

  pwr_seq_batflag u_bf (
    .clk        (clk),
    .rst        (rst),
    .supply_low (supply_low),
    .rd         (mode_rd),
    .flag       (batfail)
  );

  pwr_seq_decode u_dec (
    .wr   (mode_wr),
    .data (mode_data),
    .bf   (batfail),
    .cmd  (cmd)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    pwr_seq_timer #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick_us),
      .load     (tmr_ld[g]),
      .load_val (tmr_val[g]),
      .zero     (tmr_zero[g])
    );
  end

  assign csb_rise = csb && !csb_q;

  always_comb begin
    state_d    = state;
    win_d      = win;
    lp_d       = lp_prev;
    stby_d     = stby_pend;
    dbg_d      = dbg_pend;
    wdd_d      = wd_dis;
    stop_arm_d = stop_arm;
    stop_run_d = stop_run;
    int_set    = 1'b0;
    tmr_ld     = '0;
    tmr_val[TM_MAIN] = RST_M1;
    tmr_val[TM_STOP] = STOP_M1;
    tmr_val[TM_INT]  = INT_M1;
    tmr_val[TM_UV]   = UV_M1;

    case (state)
      ST_UNPOW: begin
        state_d         = ST_NREQ;
        win_d           = 1'b0;
        tmr_ld[TM_MAIN] = 1'b1;
      end
      ST_NREQ: begin
        case (cmd)
          C_NORM:  begin stby_d = 1'b0; dbg_d = 1'b0; end
          C_STBY:  begin stby_d = 1'b1; dbg_d = 1'b0; end
          C_DBG:   begin stby_d = 1'b0; dbg_d = 1'b1; end
          C_SLEEP: lp_d = ST_SLEEP;
          C_STOP:  lp_d = ST_STOP;
          default: ;
        endcase
        if (!win) begin
          if (tmr_zero[TM_MAIN]) begin
            win_d            = 1'b1;
            tmr_ld[TM_MAIN]  = 1'b1;
            tmr_val[TM_MAIN] = CFG_M1;
          end
        end else if (wdt_wr) begin
          state_d = stby_d ? ST_STBY : ST_NORM;
          wdd_d   = wd_dis || dbg_d;
        end else if (tmr_zero[TM_MAIN]) begin
          if (batfail) begin
            state_d         = ST_RESET;
            tmr_ld[TM_MAIN] = 1'b1;
          end else begin
            state_d = lp_prev;
          end
        end
      end
      ST_NORM, ST_STBY: begin
        if (vreg_uv || (wd_fault && !wd_dis)) begin
          state_d         = ST_RESET;
          tmr_ld[TM_MAIN] = 1'b1;
        end else begin
          case (cmd)
            C_NORM:  begin state_d = ST_NORM; stop_arm_d = 1'b0; stop_run_d = 1'b0; end
            C_STBY:  begin state_d = ST_STBY; stop_arm_d = 1'b0; stop_run_d = 1'b0; end
            C_DBG:   begin state_d = ST_NORM; wdd_d = 1'b1; stop_arm_d = 1'b0; stop_run_d = 1'b0; end
            C_SLEEP: begin state_d = ST_SLEEP; lp_d = ST_SLEEP; end
            C_STOP:  stop_arm_d = 1'b1;
            default: ;
          endcase
          if (stop_arm && frame_end) begin
            stop_arm_d      = 1'b0;
            stop_run_d      = 1'b1;
            tmr_ld[TM_STOP] = 1'b1;
          end
          if (stop_run && tmr_zero[TM_STOP]) begin
            state_d    = ST_STOP;
            lp_d       = ST_STOP;
            stop_run_d = 1'b0;
          end
        end
      end
      ST_STOP, ST_SLEEP: begin
        if (wake || csb_rise) begin
          state_d         = ST_NREQ;
          win_d           = 1'b0;
          tmr_ld[TM_MAIN] = 1'b1;
          int_set         = (state == ST_STOP);
        end
      end
      ST_RESET: begin
        if (vreg_uv && tmr_zero[TM_UV]) begin
          state_d = ST_SLEEP;
        end else if (!vreg_uv && tmr_zero[TM_MAIN]) begin
          state_d         = ST_NREQ;
          win_d           = 1'b0;
          tmr_ld[TM_MAIN] = 1'b1;
        end
      end
      default: begin
        state_d         = ST_NREQ;
        win_d           = 1'b0;
        tmr_ld[TM_MAIN] = 1'b1;
      end
    endcase

    if (state_d == ST_NREQ && state != ST_NREQ) begin
      stby_d = 1'b0;
      dbg_d  = 1'b0;
    end
    if (state_d != ST_NORM && state_d != ST_STBY) begin
      stop_arm_d = 1'b0;
      stop_run_d = 1'b0;
    end

    tmr_ld[TM_INT] = int_set;
    tmr_ld[TM_UV]  = !(state == ST_RESET && vreg_uv);
    int_act_d      = int_set || (int_act && !tmr_zero[TM_INT]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_UNPOW;
      win         <= 1'b0;
      lp_prev     <= ST_SLEEP;
      stby_pend   <= 1'b0;
      dbg_pend    <= 1'b0;
      wd_dis      <= 1'b0;
      stop_arm    <= 1'b0;
      stop_run    <= 1'b0;
      int_act     <= 1'b0;
      csb_q       <= 1'b1;
      main_en     <= 1'b0;
      main_lowpwr <= 1'b0;
      sec_en      <= 1'b0;
      rst_n_out   <= 1'b0;
      int_n       <= 1'b1;
      mode_chg    <= 1'b0;
    end else begin
      state       <= state_d;
      win         <= win_d;
      lp_prev     <= lp_d;
      stby_pend   <= stby_d;
      dbg_pend    <= dbg_d;
      wd_dis      <= wdd_d;
      stop_arm    <= stop_arm_d;
      stop_run    <= stop_run_d;
      int_act     <= int_act_d;
      csb_q       <= csb;
      main_en     <= (state_d != ST_SLEEP) && (state_d != ST_UNPOW);
      main_lowpwr <= (state_d == ST_STOP);
      sec_en      <= (state_d == ST_NORM);
      rst_n_out   <= !((state_d == ST_RESET) || (state_d == ST_UNPOW) ||
                       ((state_d == ST_NREQ) && !win_d));
      int_n       <= !int_act_d;
      mode_chg    <= (state_d != state);
    end
  end

  assign state_o    = state;
  assign wd_disable = wd_dis;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       supply_low,
  input logic       mode_rd,
  input logic       main_en,
  input logic       main_lowpwr,
  input logic       sec_en,
  input logic       rst_n_out,
  input logic       int_n,
  input logic       batfail,
  input logic [2:0] state_o,
  input logic       mode_chg
);
  assert_sec_only_norm_R11: assert property (@(posedge clk) disable iff (rst)
    sec_en |-> (state_o == 3'd2));

  assert_main_off_R11: assert property (@(posedge clk) disable iff (rst)
    !main_en |-> (state_o == 3'd5 || state_o == 3'd0));

  assert_stop_lowpwr_R11: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4) |-> (main_lowpwr && main_en));

  assert_run_no_reset_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 || state_o == 3'd3) |-> rst_n_out);

  assert_bf_set_R6: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> batfail);

  assert_bf_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(batfail) |-> $past(mode_rd));

  assert_int_in_nreq_R12: assert property (@(posedge clk) disable iff (rst)
    !int_n |-> (state_o == 3'd1));

  assert_chg_marks_new_R13: assert property (@(posedge clk) disable iff (rst)
    mode_chg |-> (state_o != $past(state_o)));

  assert_no_chg_stable_R13: assert property (@(posedge clk) disable iff (rst)
    !mode_chg |-> $stable(state_o));
endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .supply_low  (supply_low),
  .mode_rd     (mode_rd),
  .main_en     (main_en),
  .main_lowpwr (main_lowpwr),
  .sec_en      (sec_en),
  .rst_n_out   (rst_n_out),
  .int_n       (int_n),
  .batfail     (batfail),
  .state_o     (state_o),
  .mode_chg    (mode_chg)
);

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
  localparam int RT = 8;
  localparam int CT = 40;
  localparam int ST = 3;
  localparam int IT = 2;
  localparam int UT = 30;

  localparam int S_UNP = 0, S_NRQ = 1, S_NRM = 2, S_SBY = 3, S_STP = 4, S_SLP = 5, S_RST = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b1;
  logic supply_low = 1'b0, vreg_uv = 1'b0, wd_fault = 1'b0, wake = 1'b0;
  logic csb = 1'b1, frame_end = 1'b0, mode_wr = 1'b0, wdt_wr = 1'b0, mode_rd = 1'b0;
  logic [2:0] mode_data = 3'd0;
  logic main_en, main_lowpwr, sec_en, rst_n_out, int_n, wd_disable, batfail, mode_chg;
  logic [2:0] state_o;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwr_seq_ctrl #(
    .RST_TICKS(RT), .CFG_TICKS(CT), .STOP_TICKS(ST), .INT_TICKS(IT), .UV_TICKS(UT)
  ) u0 (
    .clk(clk), .rst(rst), .tick_us(tick_us), .supply_low(supply_low), .vreg_uv(vreg_uv),
    .wd_fault(wd_fault), .wake(wake), .csb(csb), .frame_end(frame_end), .mode_wr(mode_wr),
    .mode_data(mode_data), .wdt_wr(wdt_wr), .mode_rd(mode_rd), .main_en(main_en),
    .main_lowpwr(main_lowpwr), .sec_en(sec_en), .rst_n_out(rst_n_out), .int_n(int_n),
    .wd_disable(wd_disable), .batfail(batfail), .state_o(state_o), .mode_chg(mode_chg)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode_chg must mark exactly the cycles where the state code moves (R13)
  logic [2:0] prev_st = 3'd0;
  always @(negedge clk) begin
    if (!rst) begin
      if (state_o != prev_st) chk_eq("R13 mode_chg on change", int'(mode_chg), 1);
      else if (mode_chg) chk_eq("R13 mode_chg without change", 1, 0);
    end
    prev_st <= state_o;
  end

  task automatic p_wake;  @(negedge clk) wake = 1;       @(negedge clk) wake = 0;       endtask
  task automatic p_wdt;   @(negedge clk) wdt_wr = 1;     @(negedge clk) wdt_wr = 0;     endtask
  task automatic p_frame; @(negedge clk) frame_end = 1;  @(negedge clk) frame_end = 0;  endtask
  task automatic p_rd;    @(negedge clk) mode_rd = 1;    @(negedge clk) mode_rd = 0;    endtask
  task automatic p_sl;    @(negedge clk) supply_low = 1; @(negedge clk) supply_low = 0; endtask
  task automatic p_wdf;   @(negedge clk) wd_fault = 1;   @(negedge clk) wd_fault = 0;   endtask
  task automatic p_csb;
    @(negedge clk) csb = 0;
    @(negedge clk) csb = 1;
    @(negedge clk);
  endtask
  task automatic wr_mode(input logic [2:0] d);
    @(negedge clk) begin mode_wr = 1; mode_data = d; end
    @(negedge clk) mode_wr = 0;
  endtask

  task automatic wait_st(input int s, input int lim, input string req);
    int n = 0;
    while (int'(state_o) != s && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk_eq(req, int'(state_o), s);
  endtask

  task automatic configure(input string req);
    int n = 0;
    while (!rst_n_out && n < RT + 4) begin
      @(negedge clk);
      n++;
    end
    p_wdt();
    chk_eq(req, int'(state_o), S_NRM);
  endtask

  function automatic int exp_after(input int cur, input int cmd, input bit bf);
    case (cmd)
      1: return S_NRM;
      2: return S_SBY;
      5: return bf ? S_NRM : cur;
      6: return bf ? S_SBY : cur;
      default: return cur;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int n;
    bit ebf;
    void'($urandom(32'd1234));

    // R1 reset state
    repeat (3) @(negedge clk);
    chk_eq("R1 state", int'(state_o), S_UNP);
    chk_eq("R1 main_en", int'(main_en), 0);
    chk_eq("R1 sec_en", int'(sec_en), 0);
    chk_eq("R1 rst_n_out", int'(rst_n_out), 0);
    chk_eq("R1 int_n", int'(int_n), 1);
    chk_eq("R1 batfail", int'(batfail), 1);
    rst = 0;
    @(negedge clk);
    chk_eq("R1 to nreq", int'(state_o), S_NRQ);

    // R2 reset pulse length, then window length
    n = 0;
    while (!rst_n_out && n < 100) begin n++; @(negedge clk); end
    chk_eq("R2 reset pulse ticks", n, RT);
    n = 0;
    while (int'(state_o) == S_NRQ && n < 200) begin n++; @(negedge clk); end
    chk_eq("R2 window ticks", n, CT);
    // R4 expiry with batfail set goes to reset
    chk_eq("R4 expiry to reset", int'(state_o), S_RST);
    n = 0;
    while (int'(state_o) == S_RST && n < 100) begin n++; @(negedge clk); end
    chk_eq("R4 reset ticks", n, RT);
    chk_eq("R4 back to nreq", int'(state_o), S_NRQ);

    // R3 wdt write during reset pulse ignored
    p_wdt();
    chk_eq("R3 wdt in pulse ignored", int'(state_o), S_NRQ);
    chk_eq("R3 pulse still low", int'(rst_n_out), 0);
    n = 0;
    while (!rst_n_out && n < 100) begin n++; @(negedge clk); end
    wr_mode(3'b010);
    p_wdt();
    chk_eq("R3 standby via pending", int'(state_o), S_SBY);
    chk_eq("R11 sec_en in standby", int'(sec_en), 0);
    chk_eq("R11 main_en in standby", int'(main_en), 1);
    chk_eq("R2 rst_n in standby", int'(rst_n_out), 1);
    wr_mode(3'b001);
    chk_eq("R7 001 normal", int'(state_o), S_NRM);
    chk_eq("R11 sec_en in normal", int'(sec_en), 1);

    // R6 battery flag
    p_rd();
    chk_eq("R6 cleared by read", int'(batfail), 0);
    p_sl();
    chk_eq("R6 set by supply_low", int'(batfail), 1);
    repeat (5) @(negedge clk);
    chk_eq("R6 held without read", int'(batfail), 1);
    p_rd();
    chk_eq("R6 cleared again", int'(batfail), 0);

    // R9 watchdog fault
    p_wdf();
    chk_eq("R9 wd_fault to reset", int'(state_o), S_RST);
    wait_st(S_NRQ, RT + 4, "R9 reset exit");
    configure("R3 configure normal");

    // R10 persistent undervoltage to sleep
    @(negedge clk) vreg_uv = 1;
    @(negedge clk);
    chk_eq("R9 uv to reset", int'(state_o), S_RST);
    n = 0;
    while (int'(state_o) == S_RST && n < 200) begin n++; @(negedge clk); end
    chk_eq("R10 uv ticks to sleep", n, UT);
    chk_eq("R10 sleep", int'(state_o), S_SLP);
    chk_eq("R11 main off in sleep", int'(main_en), 0);
    vreg_uv = 0;

    // R12 csb rise wakes sleep; R5 fallback to sleep
    p_csb();
    chk_eq("R12 csb wake sleep", int'(state_o), S_NRQ);
    wait_st(S_SLP, RT + CT + 5, "R5 fallback sleep");

    // R12 wake strobe, R8 stop delay
    p_wake();
    chk_eq("R12 wake from sleep", int'(state_o), S_NRQ);
    chk_eq("R12 no int from sleep", int'(int_n), 1);
    configure("R3 configure normal 2");
    wr_mode(3'b011);
    repeat (5) @(negedge clk);
    chk_eq("R8 stop waits for frame", int'(state_o), S_NRM);
    p_frame();
    n = 0;
    while (int'(state_o) != S_STP && n < 50) begin n++; @(negedge clk); end
    chk_eq("R8 stop delay ticks", n, ST);
    chk_eq("R11 lowpwr in stop", int'(main_lowpwr), 1);
    chk_eq("R11 sec off in stop", int'(sec_en), 0);
    chk_eq("R11 main on in stop", int'(main_en), 1);

    // R12 interrupt pulse, R5 fallback to stop
    p_wake();
    chk_eq("R12 wake from stop", int'(state_o), S_NRQ);
    n = 0;
    while (!int_n && n < 50) begin n++; @(negedge clk); end
    chk_eq("R12 int pulse ticks", n, IT);
    wait_st(S_STP, RT + CT + 5, "R5 fallback stop");
    p_csb();
    chk_eq("R12 csb wake stop", int'(state_o), S_NRQ);
    configure("R3 configure normal 3");

    // R7 111 is stop too
    wr_mode(3'b111);
    p_frame();
    wait_st(S_STP, ST + 3, "R7 111 stop");
    p_wake();
    configure("R3 configure normal 4");

    // R9 reset held while uv persists
    @(negedge clk) vreg_uv = 1;
    @(negedge clk);
    repeat (RT + 2) @(negedge clk);
    chk_eq("R9 reset held under uv", int'(state_o), S_RST);
    vreg_uv = 0;
    wait_st(S_NRQ, 4, "R9 exit after uv clears");
    configure("R3 configure normal 5");

    // R7 debug command and R9 ignored fault
    p_sl();
    wr_mode(3'b101);
    chk_eq("R7 101 normal", int'(state_o), S_NRM);
    chk_eq("R7 wd_disable", int'(wd_disable), 1);
    p_wdf();
    repeat (2) @(negedge clk);
    chk_eq("R9 fault ignored when disabled", int'(state_o), S_NRM);

    // Random commands R7 / R6
    ebf = 1;
    for (int i = 0; i < 40; i++) begin
      int r, cmd, op, cur;
      r = int'($urandom % 5);
      cmd = (r == 0) ? 0 : (r == 1) ? 1 : (r == 2) ? 2 : (r == 3) ? 5 : 6;
      op = int'($urandom % 3);
      if (op == 1) begin p_sl(); ebf = 1; end
      else if (op == 2) begin p_rd(); ebf = 0; end
      chk_eq("R6 random flag", int'(batfail), int'(ebf));
      cur = int'(state_o);
      wr_mode(3'(cmd));
      chk_eq("R7 random command", int'(state_o), exp_after(cur, cmd, ebf));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule